// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM Bank

This block is one bank of synchronous static RAM whose address, control and write data are all captured on the rising clock edge. The read path is flow-through: the word at the captured address leaves the block combinationally in the cycle that follows the capturing edge, with no output register. Each word is 72 bits wide and is split into eight 9-bit lanes. Each lane holds one data byte and one parity bit, and each lane can be written on its own.

Accesses begin on one of two address strobes, and each strobe follows its own rule. The processor strobe only ever begins a read. The controller strobe begins a read or a write according to the write controls, or it deselects the bank. After an access has begun, a 4-word sequential burst can be continued or held with the advance input. Holding the controller strobe low and the other two strobe inputs high gives a plain single-access synchronous RAM. The output driver's high-impedance state is represented by a valid flag. An asynchronous output enable gates both the flag and the data.

Top module: `ft_sram`

## Requirements
- R1: While reset is asserted and after its release with no access, `rvalid` is low and `rdata` is all zeros.
- R2: At an edge with `proc_stb_n` low and `bank_en_n` low, the bank captures `addr` and begins a read whatever `wr_all_n`, `lane_wr_en_n` and `lane_sel_n` are, and no lane of the array is written.
- R3: At an edge with `ctrl_stb_n` low, `bank_en_n` low and `proc_stb_n` high, the bank captures `addr`. The access is a write if `wr_all_n` is low, or if `lane_wr_en_n` is low and any bit of `lane_sel_n` is low. Otherwise it is a read.
- R4: At an edge with `ctrl_stb_n` low and `bank_en_n` high, the bank is deselected. It keeps `rvalid` low and ignores all write controls until an accepted strobe selects it again. `proc_stb_n` low with `bank_en_n` high is not an accepted strobe.
- R5: At a write with `wr_all_n` low, all 72 bits are written regardless of `lane_wr_en_n` and `lane_sel_n`.
- R6: With `wr_all_n` high, lane i (bits 9i to 9i+8, where bit 9i+8 is that lane's parity bit) is written only when `lane_wr_en_n` is low and `lane_sel_n[i]` is low. The other lanes keep their contents.
- R7: At an edge where the bank is selected, both strobes are high and `burst_adv_n` is low, the access moves to the next burst address. The low two address bits count up modulo 4 and the upper bits do not change.
- R8: At an edge where the bank is selected, both strobes are high and `burst_adv_n` is high, the access stays at the current address.
- R9: During a burst continue or hold, the write controls decide between read and write as in R3, R5 and R6, and write data goes to the address that the burst step selects.
- R10: Read data for an access captured at a rising edge appears on `rdata` before the next rising edge.
- R11: `rvalid` is high only while a read access is selected and `out_en_n` is low. `out_en_n` acts without a clock. `rdata` is zero whenever `rvalid` is low, so write cycles show no data.
- R12: With `ctrl_stb_n` held low, `proc_stb_n` and `burst_adv_n` held high and `bank_en_n` low, every clock performs one read or one write at the supplied address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_en_n | input | 1 | Bank enable, active low, registered |
| proc_stb_n | input | 1 | Read-only address strobe, active low |
| ctrl_stb_n | input | 1 | Read/write/deselect address strobe, active low |
| burst_adv_n | input | 1 | Burst advance, low = next address, high = hold |
| wr_all_n | input | 1 | Full-word write, active low |
| lane_wr_en_n | input | 1 | Enables per-lane write gating, active low |
| lane_sel_n | input | LANES | Per-lane write enables, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data, lane i at bits 9i to 9i+8 |
| rdata | output | LANES*LANE_W | Flow-through read data, zero when not valid |
| rvalid | output | 1 | Read data is being driven |

## Verification
A wrong burst address first shows up as the wrong stored word on `rdata` in the cycle right after the advancing edge. A mis-steered write does not appear until that location is read back later, so every write pattern in the bench is followed by a read of the lanes it did or did not touch. A stuck select or write flag shows on `rvalid` within one edge, because `rvalid` depends directly on those two state bits and on the output enable.

// File: rtl/ft_sram_pkg.sv
package ft_sram_pkg;

  // Decoded per-edge access decision
  typedef struct packed {
    logic load;   // capture external address
    logic step;   // advance burst address
    logic sel;    // bank selected after the edge
    logic wr;     // access after the edge is a write
  } ft_ctl_t;

endpackage

// File: rtl/ft_sram_ctrl.sv
module ft_sram_ctrl
  import ft_sram_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic             sel_q,
  input  logic             bank_en_n,
  input  logic             proc_stb_n,
  input  logic             ctrl_stb_n,
  input  logic             burst_adv_n,
  input  logic             wr_all_n,
  input  logic             lane_wr_en_n,
  input  logic [LANES-1:0] lane_sel_n,
  output ft_ctl_t          ctl,
  output logic [LANES-1:0] lane_we
);

  logic acc_proc, acc_ctrl, desel, cont, any_wr, wr_path;

  always_comb begin
    acc_proc = !proc_stb_n && !bank_en_n;
    acc_ctrl = !ctrl_stb_n && !bank_en_n && !acc_proc;
    desel    = !ctrl_stb_n && bank_en_n;
    cont     = sel_q && !acc_proc && !acc_ctrl && !desel;
    any_wr   = !wr_all_n || (!lane_wr_en_n && (|(~lane_sel_n)));
    wr_path  = acc_ctrl || cont;

    ctl.load = acc_proc || acc_ctrl;
    ctl.step = cont && !burst_adv_n;
    ctl.sel  = ctl.load || (sel_q && !desel);
    ctl.wr   = wr_path && any_wr;
  end

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_we
      assign lane_we[g] = wr_path && (!wr_all_n || (!lane_wr_en_n && !lane_sel_n[g]));
    end
  endgenerate

endmodule

// File: rtl/ft_sram_burst.sv
module ft_sram_burst #(
  parameter int ADDR_W  = 8,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] nxt_addr
);

  logic [ADDR_W-1:0]  addr_q;
  logic [BURST_W-1:0] low_inc;

  always_comb begin
    low_inc = addr_q[BURST_W-1:0] + 1'b1;
    if (load)
      nxt_addr = ext_addr;
    else if (step)
      nxt_addr = {addr_q[ADDR_W-1:BURST_W], low_inc};
    else
      nxt_addr = addr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      addr_q <= '0;
    else if (load || step)
      addr_q <= nxt_addr;
  end

  assign cur_addr = addr_q;

endmodule

// File: rtl/ft_sram_array.sv
module ft_sram_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 8,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        we,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
        if (we[g])
          mem[waddr] <= wdata[g*LANE_W +: LANE_W];
      end

      assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
    end
  endgenerate

endmodule

// File: rtl/ft_sram.sv
module ft_sram
  import ft_sram_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int LANES   = 8,
  parameter int LANE_W  = 9,
  parameter int BURST_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bank_en_n,
  input  logic                    proc_stb_n,
  input  logic                    ctrl_stb_n,
  input  logic                    burst_adv_n,
  input  logic                    wr_all_n,
  input  logic                    lane_wr_en_n,
  input  logic [LANES-1:0]        lane_sel_n,
  input  logic                    out_en_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rvalid
);

  localparam int DATA_W = LANES * LANE_W;

  ft_ctl_t           ctl;
  logic [LANES-1:0]  lane_we;
  logic [ADDR_W-1:0] cur_addr, nxt_addr;
  logic [DATA_W-1:0] arr_rd;
  logic              sel_q, wr_q;
  logic              sel_d, wr_d;

  ft_sram_ctrl #(.LANES(LANES)) u_ctrl (
    .sel_q        (sel_q),
    .bank_en_n    (bank_en_n),
    .proc_stb_n   (proc_stb_n),
    .ctrl_stb_n   (ctrl_stb_n),
    .burst_adv_n  (burst_adv_n),
    .wr_all_n     (wr_all_n),
    .lane_wr_en_n (lane_wr_en_n),
    .lane_sel_n   (lane_sel_n),
    .ctl          (ctl),
    .lane_we      (lane_we)
  );

  ft_sram_burst #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_burst (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ctl.load),
    .step     (ctl.step),
    .ext_addr (addr),
    .cur_addr (cur_addr),
    .nxt_addr (nxt_addr)
  );

  ft_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk   (clk),
    .we    (lane_we),
    .waddr (nxt_addr),
    .wdata (wdata),
    .raddr (cur_addr),
    .rdata (arr_rd)
  );

  // next-state
  always_comb begin
    sel_d = ctl.sel;
    wr_d  = ctl.wr;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      wr_q  <= 1'b0;
    end else begin
      sel_q <= sel_d;
      wr_q  <= wr_d;
    end
  end

  // flow-through output, gated by the asynchronous enable
  assign rvalid = sel_q && !wr_q && !out_en_n;
  assign rdata  = rvalid ? arr_rd : '0;

endmodule

// File: rtl/ft_sram_chk.sv
module ft_sram_chk #(
  parameter int DATA_W = 72
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bank_en_n,
  input logic              proc_stb_n,
  input logic              ctrl_stb_n,
  input logic              burst_adv_n,
  input logic              wr_all_n,
  input logic              lane_wr_en_n,
  input logic              out_en_n,
  input logic [DATA_W-1:0] rdata,
  input logic              rvalid
);

  AST_PROC_READS: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_stb_n && !bank_en_n) |=> (rvalid || out_en_n)); // R2

  AST_CTRL_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_stb_n && !ctrl_stb_n && !bank_en_n && !wr_all_n) |=> !rvalid); // R3

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_stb_n && bank_en_n) |=> !rvalid); // R4

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && proc_stb_n && ctrl_stb_n && burst_adv_n && wr_all_n && lane_wr_en_n)
    |=> ($stable(rdata) || out_en_n)); // R8

  AST_OE_GATES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> !rvalid); // R11

  AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |-> (rdata == '0)); // R11

endmodule

bind ft_sram ft_sram_chk #(.DATA_W(LANES*LANE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bank_en_n    (bank_en_n),
  .proc_stb_n   (proc_stb_n),
  .ctrl_stb_n   (ctrl_stb_n),
  .burst_adv_n  (burst_adv_n),
  .wr_all_n     (wr_all_n),
  .lane_wr_en_n (lane_wr_en_n),
  .out_en_n     (out_en_n),
  .rdata        (rdata),
  .rvalid       (rvalid)
);

// File: tb/ft_sram_test.sv
`timescale 1ns/1ps
module ft_sram_test;

  localparam int AW = 8;
  localparam int DW = 72;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bank_en_n, proc_stb_n, ctrl_stb_n, burst_adv_n;
  logic          wr_all_n, lane_wr_en_n, out_en_n;
  logic [7:0]    lane_sel_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic          rvalid;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  ft_sram uut (
    .clk(clk), .rst_n(rst_n), .bank_en_n(bank_en_n), .proc_stb_n(proc_stb_n),
    .ctrl_stb_n(ctrl_stb_n), .burst_adv_n(burst_adv_n), .wr_all_n(wr_all_n),
    .lane_wr_en_n(lane_wr_en_n), .lane_sel_n(lane_sel_n), .out_en_n(out_en_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
  );

  localparam logic [DW-1:0] D1 = 72'h1A_2B3C_4D5E_6F70_8192;
  localparam logic [DW-1:0] DB = 72'hE5_F0E1_D2C3_B4A5_9687;
  localparam logic [DW-1:0] DF = 72'h96_0F1E_2D3C_4B5A_6978;
  localparam logic [DW-1:0] WX = 72'h55_AA55_AA55_AA55_AA55;

  function automatic logic [DW-1:0] pat(input logic [7:0] k);
    return {k, {8{k ^ 8'h3C}}} ^ 72'h01_0203_0405_0607_0809;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock with the given inputs; returns positioned at the following falling edge.
  task automatic cyc(input logic en_n, input logic ps_n, input logic cs_n, input logic adv,
                     input logic gw, input logic lwe, input logic [7:0] ls,
                     input logic [AW-1:0] a, input logic [DW-1:0] d);
    bank_en_n = en_n; proc_stb_n = ps_n; ctrl_stb_n = cs_n; burst_adv_n = adv;
    wr_all_n = gw; lane_wr_en_n = lwe; lane_sel_n = ls; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sync_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'hFF, a, d);
  endtask

  task automatic sync_rd(input logic [AW-1:0] a);
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'hFF, a, '0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; out_en_n = 1'b0;
    bank_en_n = 1'b1; proc_stb_n = 1'b1; ctrl_stb_n = 1'b1; burst_adv_n = 1'b1;
    wr_all_n = 1'b1; lane_wr_en_n = 1'b1; lane_sel_n = 8'hFF; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    check("R1 rvalid in reset", {71'd0, rvalid}, '0);
    check("R1 rdata in reset", rdata, '0);
    rst_n = 1'b1;
    cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'hFF, '0, '0);
    check("R1 rvalid after release", {71'd0, rvalid}, '0);
  endtask

  task automatic t_sync;
    sync_wr(8'h10, D1);
    check("R11 write cycle quiet", {71'd0, rvalid}, '0);
    sync_wr(8'h11, pat(8'h11));
    sync_rd(8'h10);
    check("R12 R10 sync read rvalid", {71'd0, rvalid}, 72'd1);
    check("R12 R3 sync read data", rdata, D1);
    sync_rd(8'h11);
    check("R12 back-to-back read", rdata, pat(8'h11));
  endtask

  task automatic t_lanes;
    logic [DW-1:0] exp;
    logic [DW-1:0] m2;
    m2  = 72'h1FF << 18;
    exp = (D1 & ~m2) | (DB & m2);
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'b1111_1011, 8'h10, DB);
    check("R6 lane write is a write", {71'd0, rvalid}, '0);
    sync_rd(8'h10);
    check("R6 lane 2 with parity only", rdata, exp);
    // lane enables low but gating disabled: a read, nothing written
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 8'h10, DF);
    check("R3 R6 gated-off lanes read", rdata, exp);
    // full write overrides gating inputs
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'hFF, 8'h10, DF);
    sync_rd(8'h10);
    check("R5 full-word write", rdata, DF);
  endtask

  task automatic t_proc;
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h10, WX);
    check("R2 processor strobe reads", rdata, DF);
    sync_rd(8'h10);
    check("R2 processor strobe wrote nothing", rdata, DF);
  endtask

  task automatic t_burst;
    for (int i = 0; i < 4; i++) sync_wr(8'h20 + 8'(i), pat(8'h20 + 8'(i)));
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'hFF, 8'h21, '0);
    check("R2 burst start", rdata, pat(8'h21));
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'hFF, 8'h00, '0);
    check("R7 burst second", rdata, pat(8'h22));
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'hFF, 8'h00, '0);
    check("R7 burst third", rdata, pat(8'h23));
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'hFF, 8'h00, '0);
    check("R7 burst wraps", rdata, pat(8'h20));
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'hFF, 8'h33, '0);
    check("R8 burst hold", rdata, pat(8'h20));
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'hFF, 8'h33, WX);
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'hFF, 8'h33, '0);
    check("R9 write during hold", rdata, WX);
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'hFF, 8'h33, '0);
    check("R9 read continues after hold", rdata, pat(8'h21));
    // write burst starting at 0x35
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'hFF, 8'h35, pat(8'h90));
    for (int i = 1; i < 4; i++)
      cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'hFF, 8'h00, pat(8'h90 + 8'(i)));
    sync_rd(8'h34);
    check("R9 R7 burst write wrapped", rdata, pat(8'h93));
    sync_rd(8'h35);
    check("R9 burst write first", rdata, pat(8'h90));
    sync_rd(8'h37);
    check("R9 burst write third", rdata, pat(8'h92));
  endtask

  task automatic t_oe;
    out_en_n = 1'b1;
    sync_rd(8'h20);
    check("R11 disabled output rvalid", {71'd0, rvalid}, '0);
    check("R11 disabled output data", rdata, '0);
    out_en_n = 1'b0;
    #0.5;
    check("R11 async enable", rdata, WX);
  endtask

  task automatic t_desel;
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'hFF, 8'h21, '0);
    check("R4 deselect", {71'd0, rvalid}, '0);
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'hFF, 8'h21, DB);
    check("R4 stays deselected", {71'd0, rvalid}, '0);
    cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'hFF, 8'h21, '0);
    check("R4 unqualified strobe ignored", {71'd0, rvalid}, '0);
    sync_rd(8'h21);
    check("R4 no write while deselected", rdata, pat(8'h21));
    sync_rd(8'h20);
    check("R4 held address untouched", rdata, WX);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_sync();
    t_lanes();
    t_proc();
    t_burst();
    t_oe();
    t_desel();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule